// File: doc/BRIEF.md
# Conditional Branch Decision Unit

This unit decides whether a conditional branch is taken and produces the program counter that follows it. It takes a 4-bit condition selector, the five status flags (zero, sign, carry, overflow, saturated), the current program counter and a 9-bit signed displacement from the instruction word. A combinational evaluator turns the selector and flags into a single hit bit. A target path sign-extends the displacement and adds it to the program counter, and in parallel forms the sequential address. Both results are captured in output registers on a valid strobe.

Selectors 0 to 7 are base conditions. Setting selector bit 3 inverts the base condition. There is one exception: the slot that would invert the unconditional case is given to the saturation test. The result register holds its value between strobes. A synchronous reset clears it, and reset takes priority over a strobe.

Top module: `brc_decide`

## Requirements
- R1: A synchronous reset sets taken_o to 0 and next_pc_o to 0 on the next rising edge.
- R2: Single-flag selectors are taken when the flag is 1: 0 tests overflow, 1 tests carry, 2 tests zero and 4 tests sign. Selectors 8, 9, 10 and 12 test the same flags for 0.
- R3: Selector 3 is taken when carry OR zero is 1. Selector 11 is taken when both are 0.
- R4: Selector 6 is taken when sign XOR overflow is 1. Selector 14 is taken when that XOR is 0.
- R5: Selector 7 is taken when zero is 1 or sign XOR overflow is 1. Selector 15 is taken when neither holds.
- R6: Selector 5 is always taken, whatever the flags. Selector 13 is taken exactly when the saturated flag is 1.
- R7: When the branch is taken, next_pc_o equals pc_i plus the 9-bit displacement sign-extended to 32 bits (bit 8 is the sign), modulo 2^32.
- R8: When the branch is not taken, next_pc_o equals pc_i plus 2, modulo 2^32.
- R9: Results appear one clock edge after valid_i is sampled high. While valid_i is low, taken_o and next_pc_o hold their values whatever the other inputs do.
- R10: When reset and valid_i are both high at the same edge, the reset result (0, 0) is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Load strobe for the result registers |
| cond_sel_i | input | 4 | Condition selector |
| flag_z_i | input | 1 | Zero flag |
| flag_s_i | input | 1 | Sign flag |
| flag_cy_i | input | 1 | Carry flag |
| flag_ov_i | input | 1 | Overflow flag |
| flag_sat_i | input | 1 | Saturated flag |
| pc_i | input | 32 | Current program counter |
| disp_i | input | 9 | Signed branch displacement |
| taken_o | output | 1 | Registered branch decision |
| next_pc_o | output | 32 | Registered next program counter |

## Verification
Two things can meet at one edge: the synchronous reset and a valid strobe carrying a taken branch with a nonzero target. The bench raises both in the same cycle, with an always-taken selector and a large negative displacement. It then reads the outputs after the edge and expects zeros, not the target (R10). The carry-out of the target adder also meets the selector decision. Taken branches with negative displacements near address zero, and fall-through near the top of the address space, must wrap modulo 2^32.

// File: rtl/brc_pkg.sv
package brc_pkg;

  typedef struct packed {
    logic z;
    logic s;
    logic cy;
    logic ov;
    logic sat;
  } brc_flags_t;

  localparam int unsigned SEL_W = 4;

  // base condition slots (selector bit 3 clear)
  localparam logic [2:0] BASE_OV     = 3'd0;
  localparam logic [2:0] BASE_CY     = 3'd1;
  localparam logic [2:0] BASE_Z      = 3'd2;
  localparam logic [2:0] BASE_LS     = 3'd3;
  localparam logic [2:0] BASE_S      = 3'd4;
  localparam logic [2:0] BASE_ALWAYS = 3'd5;
  localparam logic [2:0] BASE_LT     = 3'd6;
  localparam logic [2:0] BASE_LE     = 3'd7;

  localparam logic [SEL_W-1:0] SEL_ALWAYS = 4'd5;
  localparam logic [SEL_W-1:0] SEL_SAT    = 4'd13;

endpackage

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
  import brc_pkg::*;
(
  input  logic [SEL_W-1:0] sel_i,
  input  brc_flags_t       flags_i,
  output logic             hit_o
);

  logic [7:0] base;
  logic       lt_term;

  assign lt_term = flags_i.s ^ flags_i.ov;

  always_comb begin
    base              = '0;
    base[BASE_OV]     = flags_i.ov;
    base[BASE_CY]     = flags_i.cy;
    base[BASE_Z]      = flags_i.z;
    base[BASE_LS]     = flags_i.cy | flags_i.z;
    base[BASE_S]      = flags_i.s;
    base[BASE_ALWAYS] = 1'b1;
    base[BASE_LT]     = lt_term;
    base[BASE_LE]     = flags_i.z | lt_term;
  end

  always_comb begin
    if (sel_i == SEL_SAT)
      hit_o = flags_i.sat;
    else if (sel_i[SEL_W-1])
      hit_o = ~base[sel_i[2:0]];
    else
      hit_o = base[sel_i[2:0]];
  end

endmodule

// File: rtl/brc_target.sv
module brc_target #(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned DISP_W = 9,
  parameter int unsigned STEP   = 2
) (
  input  logic [PC_W-1:0]   pc_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic              hit_i,
  output logic [PC_W-1:0]   next_o
);

  localparam int unsigned EXT_W = PC_W - DISP_W;

  logic [PC_W-1:0] disp_ext;
  logic [PC_W-1:0] jump_pc;
  logic [PC_W-1:0] seq_pc;

  generate
    if (EXT_W > 0) begin : g_ext
      assign disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
    end else begin : g_trunc
      assign disp_ext = disp_i[PC_W-1:0];
    end
  endgenerate

  assign jump_pc = pc_i + disp_ext;
  assign seq_pc  = pc_i + PC_W'(STEP);
  assign next_o  = hit_i ? jump_pc : seq_pc;

endmodule

// File: rtl/brc_decide.sv
module brc_decide
  import brc_pkg::*;
#(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned DISP_W = 9,
  parameter int unsigned STEP   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [3:0]        cond_sel_i,
  input  logic              flag_z_i,
  input  logic              flag_s_i,
  input  logic              flag_cy_i,
  input  logic              flag_ov_i,
  input  logic              flag_sat_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic              taken_o,
  output logic [PC_W-1:0]   next_pc_o
);

  brc_flags_t      flags;
  logic            hit;
  logic [PC_W-1:0] next_pc_d;

  assign flags = '{z: flag_z_i, s: flag_s_i, cy: flag_cy_i,
                   ov: flag_ov_i, sat: flag_sat_i};

  brc_cond_eval u_cond (
    .sel_i   (cond_sel_i),
    .flags_i (flags),
    .hit_o   (hit)
  );

  brc_target #(
    .PC_W   (PC_W),
    .DISP_W (DISP_W),
    .STEP   (STEP)
  ) u_tgt (
    .pc_i   (pc_i),
    .disp_i (disp_i),
    .hit_i  (hit),
    .next_o (next_pc_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      taken_o   <= 1'b0;
      next_pc_o <= '0;
    end else if (valid_i) begin
      taken_o   <= hit;
      next_pc_o <= next_pc_d;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!taken_o && next_pc_o == '0)); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> ($stable(taken_o) && $stable(next_pc_o))); // R9

  AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (valid_i && cond_sel_i == SEL_ALWAYS) |=> taken_o); // R6

  AST_SAT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (valid_i && cond_sel_i == SEL_SAT) |=> (taken_o == $past(flag_sat_i))); // R6

  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !hit) |=> (next_pc_o == $past(pc_i) + PC_W'(STEP))); // R8

endmodule

// File: tb/tb_brc_decide.sv
module tb_brc_decide;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0;
  logic [3:0]  cond_sel_i = '0;
  logic        flag_z_i = 1'b0, flag_s_i = 1'b0, flag_cy_i = 1'b0;
  logic        flag_ov_i = 1'b0, flag_sat_i = 1'b0;
  logic [31:0] pc_i = '0;
  logic [8:0]  disp_i = '0;
  logic        taken_o;
  logic [31:0] next_pc_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  brc_decide dut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .cond_sel_i(cond_sel_i),
    .flag_z_i(flag_z_i), .flag_s_i(flag_s_i), .flag_cy_i(flag_cy_i),
    .flag_ov_i(flag_ov_i), .flag_sat_i(flag_sat_i),
    .pc_i(pc_i), .disp_i(disp_i), .taken_o(taken_o), .next_pc_o(next_pc_o)
  );

  function automatic logic ref_taken(input logic [3:0] s, input logic [4:0] f);
    logic z, sg, cy, ov, sat, lt;
    {z, sg, cy, ov, sat} = f;
    lt = sg ^ ov;
    case (s)
      4'd0:  return ov;
      4'd1:  return cy;
      4'd2:  return z;
      4'd3:  return cy | z;
      4'd4:  return sg;
      4'd5:  return 1'b1;
      4'd6:  return lt;
      4'd7:  return z | lt;
      4'd8:  return !ov;
      4'd9:  return !cy;
      4'd10: return !z;
      4'd11: return !(cy | z);
      4'd12: return !sg;
      4'd13: return sat;
      4'd14: return !lt;
      default: return !(z | lt);
    endcase
  endfunction

  function automatic logic [31:0] ref_pc(input logic tk, input logic [31:0] pc,
                                         input logic [8:0] d);
    return tk ? pc + {{23{d[8]}}, d} : pc + 32'd2;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  // drive one strobe at a falling edge, sample at the next falling edge
  task automatic issue(input string req, input logic [3:0] s, input logic [4:0] f,
                       input logic [31:0] pc, input logic [8:0] d);
    logic tk;
    @(negedge clk);
    valid_i = 1'b1; cond_sel_i = s; pc_i = pc; disp_i = d;
    {flag_z_i, flag_s_i, flag_cy_i, flag_ov_i, flag_sat_i} = f;
    @(negedge clk);
    valid_i = 1'b0;
    tk = ref_taken(s, f);
    check(req, {31'd0, taken_o}, {31'd0, tk});
    check(req, next_pc_o, ref_pc(tk, pc, d));
  endtask

  task automatic sweep(input string req, input logic [3:0] s);
    for (int f = 0; f < 32; f++)
      issue(req, s, 5'(f), 32'h0000_1000 + 32'(f * 4), 9'(f * 7));
  endtask

  task automatic t_reset;
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1", {31'd0, taken_o}, 32'd0);
    check("R1", next_pc_o, 32'd0);
    rst = 1'b0;
  endtask

  task automatic t_single_flags;
    sweep("R2", 4'd0); sweep("R2", 4'd1); sweep("R2", 4'd2); sweep("R2", 4'd4);
    sweep("R2", 4'd8); sweep("R2", 4'd9); sweep("R2", 4'd10); sweep("R2", 4'd12);
  endtask

  task automatic t_unsigned;  sweep("R3", 4'd3); sweep("R3", 4'd11); endtask
  task automatic t_signed_lt; sweep("R4", 4'd6); sweep("R4", 4'd14); endtask
  task automatic t_signed_le; sweep("R5", 4'd7); sweep("R5", 4'd15); endtask
  task automatic t_sat_always; sweep("R6", 4'd5); sweep("R6", 4'd13); endtask

  task automatic t_target_math;
    issue("R7", 4'd5, 5'd0, 32'h0000_0010, 9'h100);   // -256, wraps below zero
    issue("R7", 4'd5, 5'd0, 32'h0000_4000, 9'h1FE);   // -2
    issue("R7", 4'd5, 5'd0, 32'hFFFF_FFF0, 9'h0FF);   // +255, wraps over top
    issue("R8", 4'd13, 5'd0, 32'hFFFF_FFFF, 9'h0AA);  // not taken, wraps
    issue("R8", 4'd2, 5'd0, 32'h1234_5678, 9'h1FF);
  endtask

  task automatic t_hold;
    issue("R9", 4'd5, 5'd0, 32'h0000_8000, 9'h040);
    @(negedge clk);
    cond_sel_i = 4'd13; flag_sat_i = 1'b0; pc_i = 32'hDEAD_0000; disp_i = 9'h013;
    @(negedge clk); @(negedge clk);
    check("R9", {31'd0, taken_o}, 32'd1);
    check("R9", next_pc_o, 32'h0000_8040);
  endtask

  task automatic t_reset_collision;
    issue("R10", 4'd5, 5'd0, 32'h0000_0200, 9'h010);
    @(negedge clk);
    rst = 1'b1; valid_i = 1'b1; cond_sel_i = 4'd5;
    pc_i = 32'h0000_9000; disp_i = 9'h180;
    @(negedge clk);
    rst = 1'b0; valid_i = 1'b0;
    check("R10", {31'd0, taken_o}, 32'd0);
    check("R10", next_pc_o, 32'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_single_flags();
    t_unsigned();
    t_signed_lt();
    t_signed_le();
    t_sat_always();
    t_target_math();
    t_hold();
    t_reset_collision();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule